// File: doc/BRIEF.md
# Program Trace Synchronization Controller

This block sits beside a processor's program-trace logic. It decides whether the next branch trace message carries a full target address (a synchronizing message) or only the bits that differ from the previous reported target (a relative message). Several conditions can require resynchronization: reset, trace being switched on, exit from low power or debug, queue overrun, dropped branch messages, an external event, and two running counters. Each condition only marks a single sticky flag. Only the next accepted branch consumes that flag.

For every direct or indirect branch accepted while program trace is enabled, the block produces one message descriptor on a valid/ready output. The descriptor holds a message type code, a source identifier, the count of sequential instructions since the previous branch, the full or relative address, and an optional branch-history word. It also carries the number of significant bits in each variable-length field, so that a downstream packer can trim them.

Top module: `trace_sync_ctrl`

## Requirements
- R1: After reset `desc_valid` is 0 and `br_ready` is 1. The first branch accepted with trace enabled produces a synchronizing descriptor.
- R2: A branch presented while `trace_en` is 0 produces no descriptor. The first branch after `trace_en` rises is synchronizing.
- R3: A pulse on `lp_exit` or on `dbg_exit` makes the next emitted descriptor synchronizing.
- R4: A pulse on `q_overrun`, `lost_secure` or `lost_collide` makes the next emitted descriptor synchronizing.
- R5: A pulse on `evt_in` forces synchronization only while `evt_ctl` equals 2'b01. With any other `evt_ctl` code it has no effect.
- R6: After PERIOD_LIMIT consecutive relative descriptors since the last synchronizing one, the next descriptor is synchronizing. A synchronizing descriptor restarts this count.
- R7: `desc_icnt` equals the number of cycles with `retire` high since the previous emitted branch, saturating at 2^ICNT_W-1. A branch taken while the count is saturated is synchronizing.
- R8: `desc_tcode` depends on `br_kind` (2'b00 direct, 2'b01 indirect, 2'b10 indirect with history, 2'b11 treated as indirect). Synchronizing messages use 11, 12 and 29. Relative messages use 3, 4 and 28.
- R9: On a synchronizing descriptor `desc_addr` is the branch target. Otherwise it is the target XOR the previously emitted target.
- R10: `desc_hist` carries `br_hist` only for kind 2'b10. For other kinds it is 0 and `desc_hist_len` is 0.
- R11: Each length field equals the position of the highest set bit of its field plus one, with a minimum of 1.
- R12: `br_ready` equals `!desc_valid || desc_ready`. While `desc_valid` is high and `desc_ready` is low, the descriptor holds steady.
- R13: A resync condition arriving in the same cycle a synchronizing descriptor is accepted stays pending for the following branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Program trace enabled |
| lp_exit | input | 1 | Pulse: CPU left a low-power state |
| dbg_exit | input | 1 | Pulse: CPU left debug mode |
| q_overrun | input | 1 | Pulse: trace message queue overran |
| lost_secure | input | 1 | Pulse: branch message dropped on secure-region access |
| lost_collide | input | 1 | Pulse: branch message dropped by queue-entry collision |
| evt_in | input | 1 | External event input |
| evt_ctl | input | 2 | Event control; 2'b01 enables event resync |
| retire | input | 1 | One sequential instruction completed this cycle |
| src_id | input | SRC_W | Source identifier copied into descriptors |
| br_valid | input | 1 | Branch event offered |
| br_ready | output | 1 | Branch event can be taken |
| br_kind | input | 2 | Branch kind |
| br_target | input | ADDR_W | Branch target address |
| br_hist | input | 32 | Branch history word |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Descriptor consumed |
| desc_sync | output | 1 | Descriptor is synchronizing |
| desc_tcode | output | 6 | Message type code |
| desc_src | output | SRC_W | Source identifier |
| desc_icnt | output | ICNT_W | Sequential instruction count |
| desc_icnt_len | output | 6 | Significant bits of icnt |
| desc_addr | output | ADDR_W | Full or relative address |
| desc_addr_len | output | 6 | Significant bits of address |
| desc_hist | output | 32 | History word |
| desc_hist_len | output | 6 | Significant bits of history, 0 if absent |

## Verification
The bench builds the block with ICNT_W=4 and PERIOD_LIMIT=6. These values let a short run push the instruction counter into saturation, and reach the periodic resync after six relative messages. Without them, each of those would take 255 messages or instructions. With a 4-bit count field, the saturated count and its length field (15 and 4) are also checked exactly. Address and history widths keep their full 32-bit defaults, so the relative-address XOR and the length calculation run over realistic values.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;

  typedef enum logic [1:0] {
    BR_DIRECT   = 2'b00,
    BR_INDIRECT = 2'b01,
    BR_HISTORY  = 2'b10,
    BR_RSVD     = 2'b11
  } br_kind_e;

  localparam logic [5:0] TC_DIR_SYNC  = 6'd11;
  localparam logic [5:0] TC_IND_SYNC  = 6'd12;
  localparam logic [5:0] TC_HIST_SYNC = 6'd29;
  localparam logic [5:0] TC_DIR_REL   = 6'd3;
  localparam logic [5:0] TC_IND_REL   = 6'd4;
  localparam logic [5:0] TC_HIST_REL  = 6'd28;

  localparam logic [1:0] EVT_RESYNC = 2'b01;

  // Highest set bit plus one, never less than one.
  function automatic logic [5:0] sig_bits(input logic [31:0] v);
    logic [5:0] n;
    n = 6'd1;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = 6'(i + 1);
    end
    return n;
  endfunction

  function automatic logic [5:0] pick_tcode(input br_kind_e k, input logic sync);
    logic [5:0] t;
    case (k)
      BR_DIRECT:  t = sync ? TC_DIR_SYNC  : TC_DIR_REL;
      BR_HISTORY: t = sync ? TC_HIST_SYNC : TC_HIST_REL;
      default:    t = sync ? TC_IND_SYNC  : TC_IND_REL;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/tsc_sync_tracker.sv
module tsc_sync_tracker #(
  parameter int ICNT_W       = 8,
  parameter int PERIOD_LIMIT = 255,
  localparam int PW          = $clog2(PERIOD_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              lp_exit,
  input  logic              dbg_exit,
  input  logic              q_overrun,
  input  logic              lost_secure,
  input  logic              lost_collide,
  input  logic              evt_in,
  input  logic [1:0]        evt_ctl,
  input  logic              retire,
  input  logic              accept,
  output logic              sync_now,
  output logic              trig_any,
  output logic              pend_q,
  output logic [PW-1:0]     period_cnt,
  output logic [ICNT_W-1:0] icnt
);
  import trace_sync_pkg::*;

  localparam logic [ICNT_W-1:0] ICNT_MAX = '1;
  localparam logic [PW-1:0]     P_LIM    = PW'(PERIOD_LIMIT);

  logic en_q, en_rise, evt_armed, period_hit, seq_hit;

  assign en_rise    = trace_en & ~en_q;
  assign evt_armed  = (evt_ctl == EVT_RESYNC);
  assign trig_any   = lp_exit | dbg_exit | q_overrun | lost_secure |
                      lost_collide | (evt_in & evt_armed);
  assign period_hit = (period_cnt == P_LIM);
  assign seq_hit    = (icnt == ICNT_MAX);
  assign sync_now   = pend_q | en_rise | period_hit | seq_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      pend_q     <= 1'b1;
      period_cnt <= '0;
      icnt       <= '0;
    end else begin
      en_q <= trace_en;
      if (accept && sync_now) pend_q <= trig_any;
      else                    pend_q <= pend_q | trig_any | en_rise;
      if (accept) begin
        icnt <= '0;
        if (sync_now)         period_cnt <= '0;
        else if (!period_hit) period_cnt <= period_cnt + 1'b1;
      end else if (retire && !seq_hit) begin
        icnt <= icnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsc_msg_builder.sv
module tsc_msg_builder #(
  parameter int ADDR_W  = 32,
  parameter int ICNT_W  = 8,
  parameter bit HIST_EN = 1'b1
) (
  input  trace_sync_pkg::br_kind_e kind,
  input  logic                     sync,
  input  logic [ADDR_W-1:0]        target,
  input  logic [ADDR_W-1:0]        prev_target,
  input  logic [31:0]              hist_in,
  input  logic [ICNT_W-1:0]        icnt,
  output logic [5:0]               tcode,
  output logic [ADDR_W-1:0]        addr,
  output logic [5:0]               addr_len,
  output logic [5:0]               icnt_len,
  output logic [31:0]              hist_out,
  output logic [5:0]               hist_len
);
  import trace_sync_pkg::*;

  assign tcode    = pick_tcode(kind, sync);
  assign addr     = sync ? target : (target ^ prev_target);
  assign addr_len = sig_bits(32'(addr));
  assign icnt_len = sig_bits(32'(icnt));

  generate
    if (HIST_EN) begin : g_hist
      assign hist_out = (kind == BR_HISTORY) ? hist_in : 32'd0;
      assign hist_len = (kind == BR_HISTORY) ? sig_bits(hist_in) : 6'd0;
    end else begin : g_nohist
      assign hist_out = 32'd0;
      assign hist_len = 6'd0;
    end
  endgenerate

endmodule

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl #(
  parameter int ADDR_W       = 32,
  parameter int ICNT_W       = 8,
  parameter int SRC_W        = 4,
  parameter int PERIOD_LIMIT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              lp_exit,
  input  logic              dbg_exit,
  input  logic              q_overrun,
  input  logic              lost_secure,
  input  logic              lost_collide,
  input  logic              evt_in,
  input  logic [1:0]        evt_ctl,
  input  logic              retire,
  input  logic [SRC_W-1:0]  src_id,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [31:0]       br_hist,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic              desc_sync,
  output logic [5:0]        desc_tcode,
  output logic [SRC_W-1:0]  desc_src,
  output logic [ICNT_W-1:0] desc_icnt,
  output logic [5:0]        desc_icnt_len,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [5:0]        desc_addr_len,
  output logic [31:0]       desc_hist,
  output logic [5:0]        desc_hist_len
);
  import trace_sync_pkg::*;

  localparam int PW = $clog2(PERIOD_LIMIT + 1);

  logic              accept, sync_now, sync_fire, trig_any, pend_q;
  logic [PW-1:0]     period_cnt;
  logic [ICNT_W-1:0] icnt;
  logic [ADDR_W-1:0] last_tgt;
  logic [5:0]        b_tcode, b_addr_len, b_icnt_len, b_hist_len;
  logic [ADDR_W-1:0] b_addr;
  logic [31:0]       b_hist;

  assign br_ready  = ~desc_valid | desc_ready;
  assign accept    = br_valid & br_ready & trace_en;
  assign sync_fire = accept & sync_now;

  tsc_sync_tracker #(.ICNT_W(ICNT_W), .PERIOD_LIMIT(PERIOD_LIMIT)) u_tracker (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .lp_exit(lp_exit),
    .dbg_exit(dbg_exit), .q_overrun(q_overrun), .lost_secure(lost_secure),
    .lost_collide(lost_collide), .evt_in(evt_in), .evt_ctl(evt_ctl),
    .retire(retire), .accept(accept), .sync_now(sync_now),
    .trig_any(trig_any), .pend_q(pend_q), .period_cnt(period_cnt), .icnt(icnt)
  );

  tsc_msg_builder #(.ADDR_W(ADDR_W), .ICNT_W(ICNT_W), .HIST_EN(1'b1)) u_builder (
    .kind(br_kind_e'(br_kind)), .sync(sync_now), .target(br_target),
    .prev_target(last_tgt), .hist_in(br_hist), .icnt(icnt), .tcode(b_tcode),
    .addr(b_addr), .addr_len(b_addr_len), .icnt_len(b_icnt_len),
    .hist_out(b_hist), .hist_len(b_hist_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_valid    <= 1'b0;
      desc_sync     <= 1'b0;
      desc_tcode    <= '0;
      desc_src      <= '0;
      desc_icnt     <= '0;
      desc_icnt_len <= '0;
      desc_addr     <= '0;
      desc_addr_len <= '0;
      desc_hist     <= '0;
      desc_hist_len <= '0;
      last_tgt      <= '0;
    end else if (accept) begin
      desc_valid    <= 1'b1;
      desc_sync     <= sync_now;
      desc_tcode    <= b_tcode;
      desc_src      <= src_id;
      desc_icnt     <= icnt;
      desc_icnt_len <= b_icnt_len;
      desc_addr     <= b_addr;
      desc_addr_len <= b_addr_len;
      desc_hist     <= b_hist;
      desc_hist_len <= b_hist_len;
      last_tgt      <= br_target;
    end else if (desc_ready) begin
      desc_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int PERIOD_LIMIT = 255,
  parameter int ADDR_W       = 32,
  localparam int PW          = $clog2(PERIOD_LIMIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trace_en,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              desc_sync,
  input logic [5:0]        desc_tcode,
  input logic [ADDR_W-1:0] desc_addr,
  input logic [5:0]        desc_addr_len,
  input logic [5:0]        desc_icnt_len,
  input logic [5:0]        desc_hist_len,
  input logic              sync_fire,
  input logic              trig_any,
  input logic              pend_q,
  input logic [PW-1:0]     period_cnt
);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_tcode)); // R12

  AST_SYNC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_sync == (desc_tcode == 6'd11 || desc_tcode == 6'd12 || desc_tcode == 6'd29)); // R8

  AST_LEN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_addr_len != 6'd0 && desc_icnt_len != 6'd0); // R11

  AST_HIST_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_tcode != 6'd29 && desc_tcode != 6'd28 |-> desc_hist_len == 6'd0); // R10

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    period_cnt <= PW'(PERIOD_LIMIT)); // R6

  AST_KEEP_LATE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fire && trig_any |=> pend_q); // R13

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en && !desc_valid |=> !desc_valid); // R2

endmodule

bind trace_sync_ctrl tsc_checker #(.PERIOD_LIMIT(PERIOD_LIMIT), .ADDR_W(ADDR_W)) u_tsc_checker (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .desc_valid(desc_valid),
  .desc_ready(desc_ready), .desc_sync(desc_sync), .desc_tcode(desc_tcode),
  .desc_addr(desc_addr), .desc_addr_len(desc_addr_len),
  .desc_icnt_len(desc_icnt_len), .desc_hist_len(desc_hist_len),
  .sync_fire(sync_fire), .trig_any(trig_any), .pend_q(pend_q),
  .period_cnt(period_cnt)
);

// File: tb/test_trace_sync_ctrl.sv
module test_trace_sync_ctrl;
  localparam int ADDR_W = 32, ICNT_W = 4, SRC_W = 4, PLIM = 6;
  localparam int ICNT_SAT = 15;

  logic clk = 0, rst_n = 0;
  logic trace_en = 0, lp_exit = 0, dbg_exit = 0, q_overrun = 0;
  logic lost_secure = 0, lost_collide = 0, evt_in = 0, retire = 0;
  logic [1:0] evt_ctl = 2'b00;
  logic [SRC_W-1:0] src_id = 4'hA;
  logic br_valid = 0, desc_ready = 1;
  logic [1:0] br_kind = 0;
  logic [ADDR_W-1:0] br_target = 0;
  logic [31:0] br_hist = 0;
  logic br_ready, desc_valid, desc_sync;
  logic [5:0] desc_tcode, desc_icnt_len, desc_addr_len, desc_hist_len;
  logic [SRC_W-1:0] desc_src;
  logic [ICNT_W-1:0] desc_icnt;
  logic [ADDR_W-1:0] desc_addr;
  logic [31:0] desc_hist;

  always #5 clk = ~clk;

  trace_sync_ctrl #(.ADDR_W(ADDR_W), .ICNT_W(ICNT_W), .SRC_W(SRC_W), .PERIOD_LIMIT(PLIM)) i_trace_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .lp_exit(lp_exit),
    .dbg_exit(dbg_exit), .q_overrun(q_overrun), .lost_secure(lost_secure),
    .lost_collide(lost_collide), .evt_in(evt_in), .evt_ctl(evt_ctl),
    .retire(retire), .src_id(src_id), .br_valid(br_valid), .br_ready(br_ready),
    .br_kind(br_kind), .br_target(br_target), .br_hist(br_hist),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_sync(desc_sync),
    .desc_tcode(desc_tcode), .desc_src(desc_src), .desc_icnt(desc_icnt),
    .desc_icnt_len(desc_icnt_len), .desc_addr(desc_addr),
    .desc_addr_len(desc_addr_len), .desc_hist(desc_hist),
    .desc_hist_len(desc_hist_len)
  );

  typedef struct {
    string       req;
    logic        sync;
    logic [5:0]  tcode;
    logic [31:0] icnt;
    logic [5:0]  icnt_len;
    logic [31:0] addr;
    logic [5:0]  addr_len;
    logic [31:0] hist;
    logic [5:0]  hist_len;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0, n_fail = 0;
  int tb_icnt = 0;
  logic [31:0] tb_last = 0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Counts significant bits by scanning downward from the top.
  function automatic logic [5:0] width_of(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 6'(i + 1);
    return 6'd1;
  endfunction

  function automatic logic [5:0] code_of(int kind, bit sync);
    if (kind == 0) return sync ? 6'd11 : 6'd3;
    if (kind == 2) return sync ? 6'd29 : 6'd28;
    return sync ? 6'd12 : 6'd4;
  endfunction

  task automatic branch(string req, int kind, logic [31:0] tgt, logic [31:0] hist,
                        bit exp_sync, bit expect_msg, bit with_ovr = 0);
    exp_t e;
    @(negedge clk);
    br_valid = 1; br_kind = 2'(kind); br_target = tgt; br_hist = hist;
    q_overrun = with_ovr;
    while (!br_ready) @(negedge clk);
    if (expect_msg) begin
      e.req = req; e.sync = exp_sync; e.tcode = code_of(kind, exp_sync);
      e.icnt = tb_icnt; e.icnt_len = width_of(tb_icnt);
      e.addr = exp_sync ? tgt : (tgt ^ tb_last);
      e.addr_len = width_of(e.addr);
      e.hist = (kind == 2) ? hist : 0;
      e.hist_len = (kind == 2) ? width_of(hist) : 6'd0;
      sb.push_back(e);
      tb_last = tgt; tb_icnt = 0;
    end
    @(negedge clk);
    br_valid = 0; q_overrun = 0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: lp_exit = 1; 1: dbg_exit = 1; 2: q_overrun = 1;
      3: lost_secure = 1; 4: lost_collide = 1; default: evt_in = 1;
    endcase
    @(negedge clk);
    lp_exit = 0; dbg_exit = 0; q_overrun = 0; lost_secure = 0;
    lost_collide = 0; evt_in = 0;
  endtask

  task automatic run_insns(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire = 1;
    end
    @(negedge clk); retire = 0;
    tb_icnt = (tb_icnt + n > ICNT_SAT) ? ICNT_SAT : tb_icnt + n;
  endtask

  // Scoreboard monitor
  always begin
    @(negedge clk); #1;
    if (rst_n && desc_valid && desc_ready) begin
      if (sb.size() == 0) check("R2", "unexpected descriptor", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "sync", desc_sync, e.sync);
        check("R8", "tcode", desc_tcode, e.tcode);
        check("R1", "src", desc_src, src_id);
        check("R7", "icnt", desc_icnt, e.icnt);
        check("R11", "icnt_len", desc_icnt_len, e.icnt_len);
        check("R9", "addr", desc_addr, e.addr);
        check("R11", "addr_len", desc_addr_len, e.addr_len);
        check("R10", "hist", desc_hist, e.hist);
        check("R10", "hist_len", desc_hist_len, e.hist_len);
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check("WD", "watchdog expired", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "desc_valid at reset", desc_valid, 0);
    check("R12", "br_ready at reset", br_ready, 1);
    @(negedge clk); rst_n = 1; trace_en = 1;
    repeat (2) @(negedge clk);
    branch("R1", 0, 32'h0000_1000, 0, 1, 1);
    run_insns(3);
    branch("R9", 1, 32'h0000_1010, 0, 0, 1);
    branch("R10", 2, 32'h0000_1014, 32'h5, 0, 1);
    pulse(0); branch("R3", 2, 32'h0000_2000, 32'h8000_0001, 1, 1);
    pulse(1); branch("R3", 0, 32'h0000_2040, 0, 1, 1);
    pulse(2); branch("R4", 1, 32'h0000_3000, 0, 1, 1);
    pulse(3); branch("R4", 1, 32'h0000_3100, 0, 1, 1);
    pulse(4); branch("R4", 0, 32'h0000_3104, 0, 1, 1);
    evt_ctl = 2'b00; pulse(5); branch("R5", 1, 32'h0000_3108, 0, 0, 1);
    evt_ctl = 2'b01; pulse(5); branch("R5", 1, 32'h0000_4000, 0, 1, 1);
    evt_ctl = 2'b10; pulse(5); branch("R5", 1, 32'h0000_4004, 0, 0, 1);
    evt_ctl = 2'b00;
    pulse(1); branch("R6", 0, 32'h0000_5000, 0, 1, 1);
    for (int i = 0; i < PLIM; i++) branch("R6", 1, 32'h0000_5000 + 32'(i * 4 + 4), 0, 0, 1);
    branch("R6", 1, 32'h0000_6000, 0, 1, 1);
    branch("R6", 1, 32'h0000_6008, 0, 0, 1);
    run_insns(5);
    branch("R7", 0, 32'h0000_6010, 0, 0, 1);
    run_insns(20);
    branch("R7", 1, 32'h0000_7000, 0, 1, 1);
    @(negedge clk); trace_en = 0;
    branch("R2", 1, 32'h0000_7100, 0, 0, 0);
    #1; check("R2", "no descriptor while disabled", desc_valid, 0);
    @(negedge clk); trace_en = 1;
    branch("R2", 1, 32'h0000_7200, 0, 1, 1);
    pulse(0);
    branch("R13", 0, 32'h0000_8000, 0, 1, 1, 1);
    branch("R13", 0, 32'h0000_8004, 0, 1, 1);
    branch("R13", 0, 32'h0000_8008, 0, 0, 1);
    @(negedge clk); desc_ready = 0;
    branch("R12", 1, 32'h0000_9000, 0, 0, 1);
    #1; held = desc_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R12", "valid held", desc_valid, 1);
      check("R12", "br_ready low", br_ready, 0);
      check("R12", "addr held", desc_addr, held);
    end
    @(negedge clk); desc_ready = 1;
    repeat (4) @(negedge clk);
    #1; check("R12", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule